// File: doc/BRIEF.md
# Cartridge PRG Bank Register Controller

This block sits on the bus of a 6502-style CPU inside a game cartridge. It watches CPU writes to a small register window just below the program area. From those writes it holds three values: a four-bit low bank field, a two-bit high bank field and a mode value. Together they select which 32 KiB slice of a program ROM of up to 2 MiB appears at CPU $8000-$FFFF. The block drives ROM address lines A20..A0 and a ROM chip-enable. It also decodes an 8 KiB unbanked work-RAM window at $6000-$7FFF and passes the low CPU address bits through to that RAM.

Two mode bits change how the bank fields are used. The swap bit exchanges data bits D0 and D1 at the moment a bank register is written. The value already latched is never rewritten, so changing the swap bit has no effect until the next bank write. The source bit chooses where ROM A16 and A15 come from. When it is clear, both lines are forced to 1. When it is set, they follow the two lowest bits of the low bank field. Because every register clears on reset, the CPU starts in 32 KiB bank 3.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After reset, ROM address bits A20..A15 equal 6'b000011, which is bank 3.
- R2: A write whose CPU address A15..A8 equals 8'h50 loads data bits 3..0 into the low bank field, whatever A7..A0 hold. Low bits 3..2 drive ROM A18..A17.
- R3: A write whose address ANDed with 16'hFB00 equals 16'h5100 loads data bits 1..0 into the high bank field, which drives ROM A20..A19. A10 is ignored, so 16'h5500 also hits this field, while 16'h5300 does not.
- R4: A write with A15..A8 equal to 8'h53 loads the mode value, where bit 0 is the swap bit and bit 2 is the source bit. When the source bit is 0, ROM A16..A15 are 2'b11. When it is 1, they equal low bank bits 1..0.
- R5: While the swap bit is 1, data bits D0 and D1 are exchanged before they are latched into the low or high bank field.
- R6: Writes to the mode value are never swapped, even when the swap bit is already 1.
- R7: Changing the swap bit leaves the latched bank fields unchanged.
- R8: A register write happens only on a clock edge where M2 is 1 and R/W is 0. In any other cycle the registers keep their values.
- R9: rom_ce_n is 0 exactly when CPU A15 is 1 and R/W is 1. ROM A14..A0 equal CPU A14..A0.
- R10: ram_ce_n is 0 exactly when the CPU address lies in $6000-$7FFF and M2 is 1. ram_addr equals CPU A12..A0.
- R11: Writes to other addresses in the window, such as 16'h5200 or 16'h5400, change no bank or mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 for a read, 0 for a write |
| cpu_m2 | input | 1 | CPU phase-2 qualifier, 1 while the bus is valid |
| rom_addr | output | 21 | Program ROM address A20..A0 |
| rom_ce_n | output | 1 | Program ROM chip-enable, active low |
| ram_addr | output | 13 | Work-RAM address A12..A0 |
| ram_ce_n | output | 1 | Work-RAM chip-enable, active low |

## Verification
The bench writes the mode value with the swap bit set and then writes the low and high fields. A design that applied the exchange at read-out instead of at capture would show A15/A16 and A19/A20 flipping as soon as the swap bit changes. The bench writes 16'h5500 and 16'h5300 to probe the masked decode of the high field. A decoder that compared the full upper byte would miss 5500, and a looser mask would let a mode write corrupt the high field. A mode write with D0 and D1 different, made while swapping is on, catches a design that swaps its own mode register. Write-shaped cycles with M2 low or R/W high show whether the write qualifier is honoured.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int CPU_AW  = 16;
  localparam int DATA_W  = 8;
  localparam int LOW_W   = 4;
  localparam int HIGH_W  = 2;
  localparam int MODE_W  = 3;
  localparam int BANK_W  = LOW_W + HIGH_W;
  localparam int WIN_AW  = 15;
  localparam int ROM_AW  = WIN_AW + BANK_W;
  localparam int RAM_AW  = 13;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] swap_d01(input logic [DATA_W-1:0] d,
                                                 input logic en);
    logic [DATA_W-1:0] r;
    r = d;
    if (en) begin
      r[0] = d[1];
      r[1] = d[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/prg_reg_decode.sv
module prg_reg_decode
  import prg_bank_pkg::*;
#(
  parameter logic [CPU_AW-1:0] LOW_ADDR  = 16'h5000,
  parameter logic [CPU_AW-1:0] LOW_MASK  = 16'hFF00,
  parameter logic [CPU_AW-1:0] HIGH_ADDR = 16'h5100,
  parameter logic [CPU_AW-1:0] HIGH_MASK = 16'hFB00,
  parameter logic [CPU_AW-1:0] MODE_ADDR = 16'h5300,
  parameter logic [CPU_AW-1:0] MODE_MASK = 16'hFF00
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  output reg_sel_e          sel,
  output logic              wr_en
);
  logic hit_low, hit_high, hit_mode;

  always_comb begin
    hit_low  = (cpu_addr & LOW_MASK)  == LOW_ADDR;
    hit_high = (cpu_addr & HIGH_MASK) == HIGH_ADDR;
    hit_mode = (cpu_addr & MODE_MASK) == MODE_ADDR;
    if (hit_low)       sel = SEL_LOW;
    else if (hit_high) sel = SEL_HIGH;
    else if (hit_mode) sel = SEL_MODE;
    else               sel = SEL_NONE;
    wr_en = cpu_m2 && !cpu_rw && (sel != SEL_NONE);
  end
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LOW_W-1:0]  low_q,
  output logic [HIGH_W-1:0] high_q,
  output logic              swap_en,
  output logic              src_sel
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [LOW_W-1:0]  low_d;
  logic [HIGH_W-1:0] high_d;
  logic              low_en, high_en, mode_en;
  logic [DATA_W-1:0] bank_data;

  always_comb begin
    bank_data = swap_d01(wr_data, mode_q[0]);
    low_en  = wr_en && (sel == SEL_LOW);
    high_en = wr_en && (sel == SEL_HIGH);
    mode_en = wr_en && (sel == SEL_MODE);
    low_d   = bank_data[LOW_W-1:0];
    high_d  = bank_data[HIGH_W-1:0];
    mode_d  = wr_data[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      mode_q <= '0;
    end else begin
      if (low_en)  low_q  <= low_d;
      if (high_en) high_q <= high_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign swap_en = mode_q[0];
  assign src_sel = mode_q[2];

  a_r7_mode_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> ($stable(low_q) && $stable(high_q)));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(low_q) && $stable(high_q) && $stable(mode_q)));
  a_r6_mode_unswapped: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (swap_en == $past(wr_data[0])));
  a_r5_low_swapped: assert property (@(posedge clk) disable iff (!rst_n)
    (low_en && swap_en) |=> (low_q[1:0] == {$past(wr_data[0]), $past(wr_data[1])}));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_bank_pkg::*;
#(
  parameter logic [2:0] RAM_TOP = 3'b011
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [LOW_W-1:0]  low_q,
  input  logic [HIGH_W-1:0] high_q,
  input  logic              src_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce_n
);
  logic [BANK_W-1:0] bank;
  logic [1:0]        lo_pair;

  always_comb begin
    lo_pair  = src_sel ? low_q[1:0] : 2'b11;
    bank     = {high_q, low_q[LOW_W-1:2], lo_pair};
    rom_addr = {bank, cpu_addr[WIN_AW-1:0]};
    rom_ce_n = !(cpu_addr[CPU_AW-1] && cpu_rw);
    ram_addr = cpu_addr[RAM_AW-1:0];
    ram_ce_n = !(cpu_m2 && (cpu_addr[CPU_AW-1:RAM_AW] == RAM_TOP));
  end
endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
  import prg_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_data,
  input  logic                cpu_rw,
  input  logic                cpu_m2,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic                rom_ce_n,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic                ram_ce_n
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= (g == 0) ? 1'b1 : rst_pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  reg_sel_e          sel;
  logic              wr_en;
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              swap_en, src_sel;

  prg_reg_decode u_dec (
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .cpu_m2   (cpu_m2),
    .sel      (sel),
    .wr_en    (wr_en)
  );

  prg_bank_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel),
    .wr_en   (wr_en),
    .wr_data (cpu_data),
    .low_q   (low_q),
    .high_q  (high_q),
    .swap_en (swap_en),
    .src_sel (src_sel)
  );

  prg_addr_map u_map (
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .cpu_m2   (cpu_m2),
    .low_q    (low_q),
    .high_q   (high_q),
    .src_sel  (src_sel),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .ram_addr (ram_addr),
    .ram_ce_n (ram_ce_n)
  );

  a_r4_forced_pair: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !src_sel |-> (rom_addr[WIN_AW+1:WIN_AW] == 2'b11));
  a_r9_rom_ce_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rom_ce_n |-> (cpu_addr[CPU_AW-1] && cpu_rw));
  a_r10_ram_ce_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ram_ce_n |-> (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF));
endmodule

// File: tb/tb_prg_bank_ctrl.sv
module tb_prg_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'hFFFC;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic [20:0] rom_addr;
  logic        rom_ce_n;
  logic [12:0] ram_addr;
  logic        ram_ce_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  int m_low = 0, m_high = 0, m_mode = 0;

  prg_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n)
  );

  always #2.5 clk = ~clk;

  // behavioural reference of the register state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_high = 0; m_mode = 0;
    end else if (cpu_m2 && !cpu_rw) begin
      int d;
      d = cpu_data;
      if ((m_mode % 2) == 1) d = (d & ~3) | ((d & 1) * 2) | ((d / 2) & 1);
      if ((cpu_addr / 256) == 'h50)          m_low = d % 16;
      else if ((cpu_addr & 'hFB00) == 'h5100) m_high = d % 4;
      else if ((cpu_addr / 256) == 'h53)     m_mode = cpu_data % 8;
    end
  end

  function automatic int exp_bank();
    int lo2;
    lo2 = ((m_mode / 4) % 2 == 1) ? (m_low % 4) : 3;
    return m_high * 16 + (m_low / 4) * 4 + lo2;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (cmp_on) begin
      int e_rom, e_ce, e_ram_ce;
      e_rom    = exp_bank() * 32768 + (cpu_addr % 32768);
      e_ce     = (cpu_addr >= 'h8000 && cpu_rw) ? 0 : 1;
      e_ram_ce = (cpu_addr >= 'h6000 && cpu_addr <= 'h7FFF && cpu_m2) ? 0 : 1;
      check(cur_req, rom_addr, e_rom, "rom_addr");
      check(cur_req, rom_ce_n, e_ce, "rom_ce_n");
      check(cur_req, ram_ce_n, e_ram_ce, "ram_ce_n");
      check(cur_req, ram_addr, cpu_addr % 8192, "ram_addr");
    end
  end

  task automatic idle();
    @(negedge clk);
    cpu_addr = 16'hFFFC; cpu_rw = 1'b1; cpu_m2 = 1'b0; cpu_data = 8'h00;
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic rw, input logic m2);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_m2 = m2;
    idle();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_cycle(a, d, 1'b0, 1'b1);
  endtask

  task automatic bank_is(input string req, input int exp);
    @(negedge clk); #1;
    check(req, rom_addr[20:15], exp, "bank");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        cur_req = "R1"; bank_is("R1", 3);
        cur_req = "R9"; bus_cycle(16'h9234, 8'h00, 1'b1, 1'b1);
        bus_cycle(16'h1234, 8'h00, 1'b1, 1'b1);
        bus_cycle(16'hC000, 8'h00, 1'b0, 1'b1);
        cur_req = "R10"; bus_cycle(16'h6ABC, 8'h00, 1'b1, 1'b1);
        bus_cycle(16'h7FFF, 8'h00, 1'b0, 1'b0);
        bus_cycle(16'h5FFF, 8'h00, 1'b1, 1'b1);
        cur_req = "R2"; wr(16'h5077, 8'hFE); bank_is("R2", 6'b001111);
        cur_req = "R4"; wr(16'h5300, 8'h04); bank_is("R4", 6'b001110);
        wr(16'h5300, 8'h00); bank_is("R4", 6'b001111);
        wr(16'h5300, 8'h04);
        cur_req = "R3"; wr(16'h5100, 8'h02); bank_is("R3", 6'b101110);
        wr(16'h5500, 8'h01); bank_is("R3", 6'b011110);
        wr(16'h5300, 8'h04); bank_is("R3", 6'b011110);
        cur_req = "R8"; bus_cycle(16'h5000, 8'h05, 1'b0, 1'b0);
        bus_cycle(16'h5000, 8'h05, 1'b1, 1'b1); bank_is("R8", 6'b011110);
        cur_req = "R11"; wr(16'h5200, 8'hFF); wr(16'h5400, 8'hFF);
        wr(16'h4000, 8'hFF); bank_is("R11", 6'b011110);
        cur_req = "R5"; wr(16'h5300, 8'h05);
        cur_req = "R7"; bank_is("R7", 6'b011110);
        cur_req = "R5"; wr(16'h5000, 8'h01); bank_is("R5", 6'b010010);
        wr(16'h5100, 8'h01); bank_is("R5", 6'b100010);
        cur_req = "R6"; wr(16'h5300, 8'h06); bank_is("R6", 6'b100010);
        wr(16'h5000, 8'h01); bank_is("R6", 6'b100001);
        wr(16'h5300, 8'h05);
        cur_req = "R7"; wr(16'h5300, 8'h04); bank_is("R7", 6'b100001);
        wr(16'h5000, 8'h01); bank_is("R7", 6'b100001);
        cur_req = "R1"; rst_n = 1'b0; bank_is("R1", 3);
        rst_n = 1'b1; repeat (3) @(negedge clk); bank_is("R1", 3);
        idle(); idle();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule